// File: doc/BRIEF.md
# Password-Gated Command Sequencer

This block is the transaction layer of a two-array secure serial memory. A bit and byte layer below it turns the two-wire bus into start and stop events, received bytes and requests for the next byte to transmit. This block decides what each byte means and answers every received byte with an acknowledge or a refusal. Both memory arrays are behavioural register files inside the block. The password comparison is done outside: the block presents the collected 64-bit word and the slot it must match, and it reads back a single match bit.

A session has a fixed order. It opens with a start, then a command byte, then eight password bytes with the first byte most significant. Every password entry starts a nonvolatile busy period, whatever the result. The host then polls with start plus F0h, and the outcome is revealed only once that busy period has ended. After a successful poll, reads and sector writes take a two-byte address, high byte first, and then stream data. Password changes take two zero bytes and the new password twice. Two service commands raise a one-cycle request.

Written sector data is held in a staging buffer. It is committed only when a stop closes the write, during a timed busy period of `WC_CYCLES` clocks.

Top module: `pwgate_seq`

## Requirements
- R1: After reset, `ack_valid`, `tx_valid`, `nv_busy`, `pw_wr`, `clr_pw_req` and `unlock_req` are all 0.
- R2: The first byte after a start is acknowledged only when the block is not busy and the byte is one of 80h, 88h, 90h, 98h, A0h, A8h, B0h, B8h, C0h, E0h or E8h. Any other byte, including F0h, is refused and the block returns to standby.
- R3: Each byte presented with `rx_valid` gets `ack_valid` high in the following cycle, with `ack_ok` giving the answer (1 acknowledges, 0 refuses). Each `tx_req` in a read session gives `tx_valid` and `tx_data` in the following cycle.
- R4: The eight password bytes are all acknowledged and are shifted into `pw_word`, first byte most significant. `pw_slot` selects the stored password to compare: 0 for 80h/A0h, 1 for 88h/A8h, 2 for 90h/B0h, 3 for 98h/B8h, and 4 for C0h/E0h/E8h. One cycle after the eighth byte, `pw_match` is sampled and `nv_busy` rises, whether or not the password matched.
- R5: A poll byte F0h is refused while busy, and the host may poll again. Once idle, F0h is acknowledged if the password matched. It is refused if the password did not match, and the block returns to standby. Any byte other than F0h is refused and returns the block to standby.
- R6: The address is two bytes, high byte first. Array 0 uses the low `A0_AW` bits and array 1 uses the low `A1_AW` bits.
- R7: A sequential read returns the byte at the current address and then increments it, wrapping from the top of the array to 0.
- R8: A start during a read session, followed by one byte, replaces only the low 8 address bits and keeps the upper bits.
- R9: Sector-write bytes go to a 32-byte sector. The index starts at the low 5 address bits and wraps inside the sector, so later bytes overwrite earlier ones. A stop after at least one byte commits the data and starts the busy period. Committed data is readable once `nv_busy` falls.
- R10: A start or stop during password, address, write-data or change input aborts the session to standby. No data is written and no busy period starts.
- R11: While busy, a command byte is refused. Start and stop events do not change the busy period, which lasts exactly `WC_CYCLES` cycles.
- R12: A password change requires two zero bytes; a non-zero byte is refused and returns the block to standby. If the two entries of the new password match, the closing stop pulses `pw_wr` for one cycle with `pw_wr_data` holding the new value and `pw_slot` naming the slot, and the busy period starts. If the entries differ, the block returns to standby without writing and without a busy period.
- R13: A successful poll after E0h pulses `clr_pw_req` for one cycle. After E8h it pulses `unlock_req` for one cycle. Both then return to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next transmit byte |
| pw_match | input | 1 | External compare result for `pw_word` against slot `pw_slot` |
| ack_valid | output | 1 | Response to the byte of the previous cycle is valid |
| ack_ok | output | 1 | 1 acknowledges, 0 refuses |
| tx_valid | output | 1 | `tx_data` holds a fresh read byte |
| tx_data | output | 8 | Read data |
| nv_busy | output | 1 | Nonvolatile busy period running |
| pw_slot | output | 3 | Password slot of the current command |
| pw_word | output | PW_BYTES*8 | Collected password |
| pw_wr | output | 1 | One-cycle strobe to store a new password |
| pw_wr_data | output | PW_BYTES*8 | New password value |
| clr_pw_req | output | 1 | One-cycle request to clear passwords and arrays |
| unlock_req | output | 1 | One-cycle request to re-enable the device |

## Verification
The decoder is swept over all 256 first-byte values; this separates the eleven legal codes from their near neighbours, such as F0h and the reserved codes. Sessions are run with a right password, a wrong password and a changed password. These separate the three poll outcomes and show that the busy delay hides the result in every case. Address patterns near each array's top and near sector edges are used. An overlong write, reads across the wrap point and a random jump inside a block above 0FFh show whether the sector index, the array mask and the partial address reload each keep the bits they should. Aborted writes and mismatched password entries check that nothing is committed.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_PWD, S_PWCHK, S_PWWAIT, S_POLL, S_AH, S_AL,
    S_RD, S_RA, S_WR, S_ZERO, S_NEW1, S_NEW2, S_NDONE
  } state_t;

  typedef enum logic [2:0] {
    K_READ, K_WRITE, K_CHG, K_CLRPW, K_UNLOCK, K_BAD
  } kind_t;

  typedef struct packed {
    kind_t      kind;
    logic       arr;
    logic [2:0] slot;
  } cmd_t;

  localparam logic [7:0] POLL_CODE = 8'hF0;

  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.kind = K_BAD;
    c.arr  = b[3];
    c.slot = 3'd0;
    case (b)
      8'h80, 8'h88:               begin c.kind = K_READ;   c.slot = {2'b00, b[3]}; end
      8'h90, 8'h98:               begin c.kind = K_WRITE;  c.slot = {2'b01, b[3]}; end
      8'hA0, 8'hA8, 8'hB0, 8'hB8: begin c.kind = K_CHG;    c.slot = {1'b0, b[4], b[3]}; end
      8'hC0:                      begin c.kind = K_CHG;    c.slot = 3'd4; end
      8'hE0:                      begin c.kind = K_CLRPW;  c.slot = 3'd4; end
      8'hE8:                      begin c.kind = K_UNLOCK; c.slot = 3'd4; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwgate_nvtimer.sv
module pwgate_nvtimer #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load && cnt == 0) cnt <= CW'(CYC);
    else if (cnt != 0)         cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != 0);

  // R11: a running busy period is never restarted or stretched
  assert_busy_countdown_R11: assert property (@(posedge clk) disable iff (rst)
    (cnt != 0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/pwgate_pagebuf.sv
module pwgate_pagebuf #(
  parameter int SB = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [$clog2(SB)-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  output logic          c_en,
  output logic [$clog2(SB)-1:0] c_idx,
  output logic [7:0]    c_data
);
  localparam int IW = $clog2(SB);

  logic [7:0]    slot_q [SB];
  logic [SB-1:0] mask;
  logic          walking;
  logic [IW-1:0] widx;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '0;
      walking <= 1'b0;
      widx    <= '0;
    end else begin
      if (clr)        mask <= '0;
      else if (wr_en) mask[wr_idx] <= 1'b1;
      if (commit) begin
        walking <= 1'b1;
        widx    <= '0;
      end else if (walking) begin
        widx <= widx + IW'(1);
        if (widx == IW'(SB - 1)) walking <= 1'b0;
      end
    end
  end

  assign c_en   = walking && mask[widx];
  assign c_idx  = widx;
  assign c_data = slot_q[widx];

  // R9: a new commit never starts while the previous one is still draining
  assert_commit_free_R9: assert property (@(posedge clk) disable iff (rst)
    commit |-> !walking);
endmodule

// File: rtl/pwgate_mem.sv
module pwgate_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwgate_seq.sv
module pwgate_seq
  import pwgate_pkg::*;
#(
  parameter int A0_AW      = 8,
  parameter int A1_AW      = 5,
  parameter int PW_BYTES   = 8,
  parameter int SECT_BYTES = 32,
  parameter int WC_CYCLES  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_start,
  input  logic                    ev_stop,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    tx_req,
  input  logic                    pw_match,
  output logic                    ack_valid,
  output logic                    ack_ok,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  output logic                    nv_busy,
  output logic [2:0]              pw_slot,
  output logic [PW_BYTES*8-1:0]   pw_word,
  output logic                    pw_wr,
  output logic [PW_BYTES*8-1:0]   pw_wr_data,
  output logic                    clr_pw_req,
  output logic                    unlock_req
);
  localparam int PWW  = PW_BYTES * 8;
  localparam int SW   = $clog2(SECT_BYTES);
  localparam int PCW  = $clog2(PW_BYTES + 1);
  localparam int AMAX = (A0_AW > A1_AW) ? A0_AW : A1_AW;
  localparam logic [AMAX-1:0] MASK0 = {AMAX{1'b1}} >> (AMAX - A0_AW);
  localparam logic [AMAX-1:0] MASK1 = {AMAX{1'b1}} >> (AMAX - A1_AW);

  initial assert (WC_CYCLES > SECT_BYTES && AMAX <= 16 && A1_AW >= SW);

  state_t            state;
  cmd_t              cmd_q;
  logic [PCW-1:0]    pcnt;
  logic              pw_ok;
  logic [7:0]        hi_q;
  logic [AMAX-1:0]   addr_q;
  logic [AMAX-SW-1:0] wbase;
  logic [SW-1:0]     widx;
  logic              any_q;
  logic              zcnt;
  logic              mism;

  cmd_t              dec;
  logic [AMAX-1:0]   amask;
  logic [15:0]       full_addr;
  logic [AMAX-1:0]   addr_ld;
  logic [15:0]       ra_ext;
  logic [AMAX-1:0]   ra_addr;
  logic              abort_ev;
  logic              rd_fire;
  logic              commit;
  logic              timer_load;
  logic              buf_wr;
  logic              buf_clr;
  logic              byte_neq;

  logic              c_en;
  logic [SW-1:0]     c_idx;
  logic [7:0]        c_data;
  logic [AMAX-1:0]   waddr;
  logic [7:0]        rd0, rd1;

  always_comb begin
    dec       = decode_cmd(rx_byte);
    amask     = cmd_q.arr ? MASK1 : MASK0;
    full_addr = {hi_q, rx_byte};
    addr_ld   = full_addr[AMAX-1:0] & amask;
    ra_ext    = 16'(addr_q);
    ra_ext[7:0] = rx_byte;
    ra_addr   = ra_ext[AMAX-1:0] & amask;
    abort_ev  = ev_start || ev_stop;
    rd_fire   = (state == S_RD) && tx_req && !abort_ev;
    commit    = (state == S_WR) && ev_stop && any_q;
    timer_load = (state == S_PWCHK) || commit || ((state == S_NDONE) && ev_stop);
    buf_wr    = (state == S_WR) && rx_valid && !abort_ev;
    buf_clr   = (state == S_AL) && rx_valid && !abort_ev;
    byte_neq  = (rx_byte != pw_wr_data[PWW-1 -: 8]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cmd_q      <= '{kind: K_BAD, arr: 1'b0, slot: 3'd0};
      ack_valid  <= 1'b0;
      ack_ok     <= 1'b0;
      tx_valid   <= 1'b0;
      pw_wr      <= 1'b0;
      clr_pw_req <= 1'b0;
      unlock_req <= 1'b0;
      pw_slot    <= '0;
      pw_word    <= '0;
      pw_wr_data <= '0;
      pcnt       <= '0;
      pw_ok      <= 1'b0;
      hi_q       <= '0;
      addr_q     <= '0;
      wbase      <= '0;
      widx       <= '0;
      any_q      <= 1'b0;
      zcnt       <= 1'b0;
      mism       <= 1'b0;
    end else begin
      ack_valid  <= rx_valid;
      ack_ok     <= 1'b0;
      tx_valid   <= 1'b0;
      pw_wr      <= 1'b0;
      clr_pw_req <= 1'b0;
      unlock_req <= 1'b0;
      case (state)
        S_IDLE: if (ev_start) state <= S_CMD;
        S_CMD: begin
          if (ev_stop) state <= S_IDLE;
          else if (!ev_start && rx_valid) begin
            if (!nv_busy && dec.kind != K_BAD) begin
              ack_ok  <= 1'b1;
              cmd_q   <= dec;
              pw_slot <= dec.slot;
              pcnt    <= '0;
              state   <= S_PWD;
            end else state <= S_IDLE;
          end
        end
        S_PWD: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            ack_ok  <= 1'b1;
            pw_word <= {pw_word[PWW-9:0], rx_byte};
            pcnt    <= pcnt + PCW'(1);
            if (pcnt == PCW'(PW_BYTES - 1)) state <= S_PWCHK;
          end
        end
        S_PWCHK: begin
          pw_ok <= pw_match;
          state <= S_PWWAIT;
        end
        S_PWWAIT: if (ev_start) state <= S_POLL;
        S_POLL: begin
          if (ev_stop) state <= S_IDLE;
          else if (!ev_start && rx_valid) begin
            if (rx_byte != POLL_CODE || (!nv_busy && !pw_ok)) state <= S_IDLE;
            else if (nv_busy) state <= S_PWWAIT;
            else begin
              ack_ok <= 1'b1;
              case (cmd_q.kind)
                K_READ, K_WRITE: state <= S_AH;
                K_CHG: begin zcnt <= 1'b0; state <= S_ZERO; end
                K_CLRPW: begin clr_pw_req <= 1'b1; state <= S_IDLE; end
                default: begin unlock_req <= 1'b1; state <= S_IDLE; end
              endcase
            end
          end
        end
        S_AH: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            ack_ok <= 1'b1;
            hi_q   <= rx_byte;
            state  <= S_AL;
          end
        end
        S_AL: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            ack_ok <= 1'b1;
            addr_q <= addr_ld;
            wbase  <= addr_ld[AMAX-1:SW];
            widx   <= addr_ld[SW-1:0];
            any_q  <= 1'b0;
            state  <= (cmd_q.kind == K_READ) ? S_RD : S_WR;
          end
        end
        S_RD: begin
          if (ev_stop) state <= S_IDLE;
          else if (ev_start) state <= S_RA;
          else if (tx_req) begin
            tx_valid <= 1'b1;
            addr_q   <= (addr_q + AMAX'(1)) & amask;
          end
        end
        S_RA: begin
          if (ev_stop) state <= S_IDLE;
          else if (!ev_start && rx_valid) begin
            ack_ok <= 1'b1;
            addr_q <= ra_addr;
            state  <= S_RD;
          end
        end
        S_WR: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            ack_ok <= 1'b1;
            widx   <= widx + SW'(1);
            any_q  <= 1'b1;
          end
        end
        S_ZERO: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            if (rx_byte == 8'h00) begin
              ack_ok <= 1'b1;
              zcnt   <= 1'b1;
              pcnt   <= '0;
              if (zcnt) state <= S_NEW1;
            end else state <= S_IDLE;
          end
        end
        S_NEW1: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            ack_ok     <= 1'b1;
            pw_wr_data <= {pw_wr_data[PWW-9:0], rx_byte};
            pcnt       <= pcnt + PCW'(1);
            mism       <= 1'b0;
            if (pcnt == PCW'(PW_BYTES - 1)) begin
              pcnt  <= '0;
              state <= S_NEW2;
            end
          end
        end
        S_NEW2: begin
          if (abort_ev) state <= S_IDLE;
          else if (rx_valid) begin
            ack_ok     <= 1'b1;
            pw_wr_data <= {pw_wr_data[PWW-9:0], pw_wr_data[PWW-1 -: 8]};
            pcnt       <= pcnt + PCW'(1);
            if (byte_neq) mism <= 1'b1;
            if (pcnt == PCW'(PW_BYTES - 1))
              state <= (mism || byte_neq) ? S_IDLE : S_NDONE;
          end
        end
        S_NDONE: begin
          if (ev_stop) begin
            pw_wr <= 1'b1;
            state <= S_IDLE;
          end else if (ev_start) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  pwgate_nvtimer #(.CYC(WC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .busy(nv_busy)
  );

  pwgate_pagebuf #(.SB(SECT_BYTES)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr_en(buf_wr), .wr_idx(widx),
    .wr_data(rx_byte), .commit(commit), .c_en(c_en), .c_idx(c_idx), .c_data(c_data)
  );

  assign waddr = {wbase, c_idx};

  pwgate_mem #(.AW(A0_AW)) u_arr0 (
    .clk(clk), .we(c_en && !cmd_q.arr), .waddr(waddr[A0_AW-1:0]), .wdata(c_data),
    .re(rd_fire && !cmd_q.arr), .raddr(addr_q[A0_AW-1:0]), .rdata(rd0)
  );

  pwgate_mem #(.AW(A1_AW)) u_arr1 (
    .clk(clk), .we(c_en && cmd_q.arr), .waddr(waddr[A1_AW-1:0]), .wdata(c_data),
    .re(rd_fire && cmd_q.arr), .raddr(addr_q[A1_AW-1:0]), .rdata(rd1)
  );

  assign tx_data = cmd_q.arr ? rd1 : rd0;

  // R11: a command byte arriving during a busy period is refused
  assert_busy_nack_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && rx_valid && !ev_start && !ev_stop && nv_busy) |=> (ack_valid && !ack_ok));
  // R4: the compare step always starts a busy period
  assert_pwchk_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_PWCHK) |=> nv_busy);
  // R5: a poll never succeeds while busy
  assert_poll_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL && rx_valid && nv_busy) |=> !ack_ok);
  // R12: a password store is always accompanied by a busy period
  assert_pwwr_busy_R12: assert property (@(posedge clk) disable iff (rst)
    pw_wr |-> nv_busy);
  // R13: service pulses and password stores never coincide
  assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pw_wr, clr_pw_req, unlock_req}));
endmodule

// File: tb/tb_pwgate_seq.sv
module tb_pwgate_seq;
  import pwgate_pkg::*;

  localparam int A0W = 10;
  localparam int A1W = 5;
  localparam int PWB = 8;
  localparam int WC  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic pw_match;
  logic ack_valid, ack_ok, tx_valid, nv_busy, pw_wr, clr_pw_req, unlock_req;
  logic [7:0] tx_data;
  logic [2:0] pw_slot;
  logic [PWB*8-1:0] pw_word, pw_wr_data;

  int nchk = 0, nfail = 0;
  logic [63:0] pwm [5];
  logic [7:0] m0 [1 << A0W];
  logic [7:0] m1 [1 << A1W];
  logic first_busy_nack;
  logic last_clr, last_unl;

  always #5 clk = ~clk;

  assign pw_match = (pw_slot <= 3'd4) ? (pw_word == pwm[pw_slot]) : 1'b0;

  pwgate_seq #(.A0_AW(A0W), .A1_AW(A1W), .PW_BYTES(PWB), .SECT_BYTES(32), .WC_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .pw_match(pw_match), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_data(tx_data), .nv_busy(nv_busy),
    .pw_slot(pw_slot), .pw_word(pw_word), .pw_wr(pw_wr), .pw_wr_data(pw_wr_data),
    .clr_pw_req(clr_pw_req), .unlock_req(unlock_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start();
    ev_start = 1'b1; tick(); ev_start = 1'b0;
  endtask

  task automatic do_stop();
    ev_stop = 1'b1; tick(); ev_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
    check("R3 response strobe", ack_valid, 1'b1);
    a = ack_ok;
  endtask

  task automatic recv(output logic [7:0] d);
    tx_req = 1'b1; tick(); tx_req = 1'b0;
    check("R3 read strobe", tx_valid, 1'b1);
    d = tx_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && nv_busy; i++) tick();
  endtask

  function automatic logic legal(input logic [7:0] c);
    return (c[7:5] == 3'b100 && c[2:0] == 3'b000) ||
           (c[7:5] == 3'b101 && c[2:0] == 3'b000) ||
           c == 8'hC0 || c == 8'hE0 || c == 8'hE8;
  endfunction

  task automatic open_session(input logic [7:0] cmd, input logic [63:0] pw, output logic ok);
    logic a, b;
    ok = 1'b0;
    first_busy_nack = 1'b0;
    last_clr = 1'b0;
    last_unl = 1'b0;
    do_start();
    send(cmd, a);
    check("R2 command accepted", a, 1'b1);
    for (int i = PWB - 1; i >= 0; i--) begin
      send(pw[i*8 +: 8], a);
      check("R4 password byte ack", a, 1'b1);
    end
    tick();
    check("R4 busy after password", nv_busy, 1'b1);
    for (int t = 0; t < 200; t++) begin
      do_start();
      b = nv_busy;
      send(8'hF0, a);
      if (t == 0) first_busy_nack = b && !a;
      if (a) begin
        ok = 1'b1;
        last_clr = clr_pw_req;
        last_unl = unlock_req;
        break;
      end
      if (!b) break;
    end
  endtask

  task automatic write_sector(input logic arr, input logic [7:0] hi, input logic [7:0] lo,
                              input int n, input int seed, input logic measure);
    logic a, ok;
    int base, idx, cnt;
    open_session(arr ? 8'h98 : 8'h90, pwm[arr ? 3 : 2], ok);
    check("R5 write session poll", ok, 1'b1);
    send(hi, a); send(lo, a);
    base = arr ? 0 : ({hi, lo} & ((1 << A0W) - 1) & ~31);
    idx  = lo & 31;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = 8'((i * seed + 17) ^ (seed << 2));
      send(v, a);
      check("R9 data byte ack", a, 1'b1);
      if (arr) m1[(idx + i) & 31] = v;
      else     m0[base + ((idx + i) & 31)] = v;
    end
    do_stop();
    check("R9 busy after write stop", nv_busy, 1'b1);
    if (measure) begin
      cnt = 1;
      for (int i = 0; i < 500 && nv_busy; i++) begin
        tick();
        if (nv_busy) cnt++;
      end
      check("R11 busy length", cnt, WC);
    end
  endtask

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic a, ok;
    logic [7:0] d;
    logic [63:0] newp;
    for (int i = 0; i < 5; i++) pwm[i] = 64'h0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 ack_valid reset", ack_valid, 0);
    check("R1 tx_valid reset", tx_valid, 0);
    check("R1 nv_busy reset", nv_busy, 0);
    check("R1 pulses reset", {pw_wr, clr_pw_req, unlock_req}, 0);

    // R2 sweep over every first byte
    for (int c = 0; c < 256; c++) begin
      do_start();
      send(8'(c), a);
      check("R2 command decode", a, legal(8'(c)));
      if (a) do_stop();
    end

    // R4 R5 wrong password: busy first, then refusal
    open_session(8'h80, 64'h1111_2222_3333_4444, ok);
    check("R5 first poll refused while busy", first_busy_nack, 1'b1);
    check("R5 wrong password refused", ok, 1'b0);
    check("R4 slot for 80h", pw_slot, 3'd0);
    wait_idle();

    // R5 non-poll byte after password
    do_start(); send(8'h88, a);
    for (int i = 0; i < PWB; i++) send(8'h00, a);
    check("R4 slot for 88h", pw_slot, 3'd1);
    tick(); wait_idle();
    do_start(); send(8'h80, a);
    check("R5 non-poll byte refused", a, 1'b0);
    do_start(); send(8'h80, a);
    check("R5 standby after bad poll", a, 1'b1);
    do_stop();

    // R9 R11 writes, with sector wrap on array 0
    write_sector(1'b0, 8'h01, 8'h23, 34, 7, 1'b1);
    write_sector(1'b0, 8'h03, 8'hE0, 32, 11, 1'b0);
    wait_idle();
    write_sector(1'b0, 8'h00, 8'h00, 32, 5, 1'b0);
    wait_idle();
    write_sector(1'b1, 8'hAB, 8'h00, 32, 13, 1'b0);
    do_start(); send(8'h80, a);
    check("R11 command refused while busy", a, 1'b0);
    do_stop();
    check("R11 stop ignored while busy", nv_busy, 1'b1);
    wait_idle();

    // R10 aborted write leaves no trace
    open_session(8'h90, pwm[2], ok);
    send(8'h01, a); send(8'h20, a); send(8'hEE, a); send(8'hEE, a);
    do_start();
    tick();
    check("R10 abort starts no busy", nv_busy, 1'b0);

    // R6 R9 readback, then R8 random read within block
    open_session(8'h80, pwm[0], ok);
    send(8'h01, a); send(8'h20, a);
    for (int i = 0; i < 32; i++) begin
      recv(d);
      check("R9 R6 array0 readback", d, m0[12'h120 + i]);
    end
    do_start(); send(8'h3A, a);
    check("R8 random address ack", a, 1'b1);
    recv(d);
    check("R8 upper bits kept", d, m0[12'h13A]);
    do_stop();

    // R7 wrap on array 0
    open_session(8'h80, pwm[0], ok);
    send(8'h03, a); send(8'hFE, a);
    recv(d); check("R7 array0 3FE", d, m0[10'h3FE]);
    recv(d); check("R7 array0 3FF", d, m0[10'h3FF]);
    recv(d); check("R7 array0 wrap 000", d, m0[0]);
    recv(d); check("R7 array0 001", d, m0[1]);
    do_stop();

    // R7 R6 wrap on array 1, high byte ignored
    open_session(8'h88, pwm[1], ok);
    send(8'h77, a); send(8'h1E, a);
    recv(d); check("R7 R6 array1 1E", d, m1[30]);
    recv(d); check("R7 array1 1F", d, m1[31]);
    recv(d); check("R7 array1 wrap 00", d, m1[0]);
    do_stop();

    // R12 password change on slot 1
    newp = 64'hC0FF_EE12_3456_789A;
    open_session(8'hA8, pwm[1], ok);
    send(8'h00, a); send(8'h00, a);
    for (int p = 0; p < 2; p++)
      for (int i = PWB - 1; i >= 0; i--) send(newp[i*8 +: 8], a);
    do_stop();
    check("R12 store pulse", pw_wr, 1'b1);
    check("R12 store data", pw_wr_data, newp);
    check("R12 store slot", pw_slot, 3'd1);
    check("R12 busy with store", nv_busy, 1'b1);
    pwm[1] = newp;
    wait_idle();
    open_session(8'h88, 64'h0, ok);
    check("R12 old password refused", ok, 1'b0);
    wait_idle();
    open_session(8'h88, newp, ok);
    check("R12 new password accepted", ok, 1'b1);
    do_stop();

    // R12 mismatched entries and non-zero filler
    open_session(8'hB0, pwm[2], ok);
    send(8'h00, a); send(8'h00, a);
    for (int i = PWB - 1; i >= 0; i--) send(newp[i*8 +: 8], a);
    for (int i = PWB - 1; i >= 0; i--) send(newp[i*8 +: 8] ^ 8'(i == 0), a);
    do_stop();
    check("R12 mismatch no store", pw_wr, 1'b0);
    check("R12 mismatch no busy", nv_busy, 1'b0);
    open_session(8'hB0, pwm[2], ok);
    send(8'h00, a);
    send(8'h01, a);
    check("R12 non-zero filler refused", a, 1'b0);
    do_stop();

    // R13 service commands
    open_session(8'hE0, pwm[4], ok);
    check("R13 clear request", {ok, last_clr, last_unl}, 3'b110);
    check("R4 slot for E0h", pw_slot, 3'd4);
    tick();
    check("R13 clear pulse one cycle", clr_pw_req, 1'b0);
    open_session(8'hE8, pwm[4], ok);
    check("R13 unlock request", {ok, last_clr, last_unl}, 3'b101);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule